// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a sum-of-products programmable logic device, together with the decode of the two global mode bits that all cells share. The cell receives the already evaluated product-term values from the AND array. A polarity bit and an I/O selection bit are its own configuration. The global bits choose registered, complex or simple behaviour. From these the cell takes one of four personalities: registered output, combinatorial I/O, always-enabled combinatorial output, or dedicated input. Each personality has its own term count, output-enable source and feedback path.

The cell drives a pin value and a tri-state enable. It returns a feedback bit to the array. In the registered personality the feedback comes from the register. In the other personalities it comes from the resolved pad level: the driven value when the cell drives the pad, the external level when it does not. Two elaboration parameters mark the cell as one of the two outer cells, which lose feedback in complex mode, or as one of the two centre cells, which stay outputs in simple mode. The register holds the inverse of the pin level. A synchronous power-on reset therefore makes an enabled registered pin read high, whatever the polarity. A preload strobe forces the register to any level, so that test sequences can start from any state.

Top module: `pla_macrocell`

## Requirements
- R1: The global bits {`mode_comb_i`,`mode_ext_i`} select the mode: 01 is registered, 11 is complex, 10 is simple. The unused code 00 behaves exactly as simple.
- R2: In every personality, `pol_i`=1 drives the pin with the term sum as it is (active high), and `pol_i`=0 drives its complement (active low).
- R3: In registered mode with `io_sel_i`=0, the OR of all eight terms, after polarity, appears on `pin_o` one clock after it is sampled. `fb_o` equals that registered pin level whether or not the pin is enabled. The register loads only in this personality.
- R4: A registered output is enabled exactly when the shared active-low pin `oe_n_i` is 0.
- R5: In registered mode with `io_sel_i`=1, `pin_o` is the OR of terms 7..1 after polarity, and term 0 alone drives `pin_oe_o`. `fb_o` is the resolved pad: `pin_o` when enabled, `pad_in_i` otherwise.
- R6: In complex mode every cell behaves as in R5 and `io_sel_i` has no effect. An outer cell (`OUTER_CELL`=1) holds `fb_o` at 0.
- R7: In simple mode with `io_sel_i`=0, the cell is an always-enabled combinatorial output of all eight terms, and `fb_o` is the pin level. With `io_sel_i`=1, `pin_oe_o` is 0 and `fb_o` follows `pad_in_i`.
- R8: In simple mode a centre cell (`CENTRE_CELL`=1) stays an enabled eight-term output even when `io_sel_i`=1, and its `fb_o` is held at 0.
- R9: A clock edge with `rst` high clears the register, so a registered, enabled pin reads 1 for either polarity.
- R10: A clock edge with `preload_i` high and `rst` low sets the registered pin level to `preload_lvl_i`, whatever the terms. Reset takes priority over preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| mode_comb_i | input | 1 | Global mode bit: 1 for non-registered families |
| mode_ext_i | input | 1 | Global mode bit: 1 for registered or complex |
| pterm_i | input | NUM_PT | Product-term values from the AND array |
| pol_i | input | 1 | Polarity: 1 active high, 0 active low |
| io_sel_i | input | 1 | Per-cell I/O configuration bit |
| oe_n_i | input | 1 | Shared output-enable pin, active low |
| preload_i | input | 1 | Preload strobe |
| preload_lvl_i | input | 1 | Pin level that a preload loads |
| pad_in_i | input | 1 | External level seen on the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe_o | output | 1 | Tri-state enable of the pad driver |
| fb_o | output | 1 | Feedback into the array |

## Verification
The checker assumes that the mode and configuration inputs stay constant across each clock edge it reasons about. The registered next-state property is therefore guarded by stable mode and I/O-selection bits over the edge. The bench changes configuration only on falling edges. It keeps the mode fixed through every registered sequence and moves only the terms, polarity, preload and enable inputs. It samples combinatorial results one nanosecond after driving them and registered results on the next falling edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Cell personality after mode decode
    typedef enum logic [1:0] {
        PERS_REG  = 2'd0,   // registered output
        PERS_CIO  = 2'd1,   // combinatorial I/O, one term as enable
        PERS_COUT = 2'd2,   // combinatorial output, always enabled
        PERS_IN   = 2'd3    // dedicated input
    } pers_e;

    // Global mode code {comb, ext}
    typedef enum logic [1:0] {
        GM_RESV    = 2'b00,
        GM_REG     = 2'b01,
        GM_SIMPLE  = 2'b10,
        GM_COMPLEX = 2'b11
    } gmode_e;

    typedef struct packed {
        pers_e pers;
        logic  mute_fb;
    } cell_cfg_t;

    typedef struct packed {
        logic lvl;
        logic drive;
    } pad_t;

    function automatic logic apply_pol(input logic sum, input logic pol);
        return pol ? sum : ~sum;
    endfunction

endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
    import pmc_pkg::*;
#(
    parameter bit OUTER_CELL  = 1'b0,
    parameter bit CENTRE_CELL = 1'b0
) (
    input  logic      mode_comb_i,
    input  logic      mode_ext_i,
    input  logic      io_sel_i,
    output cell_cfg_t cfg_o
);
    gmode_e gm;

    always_comb begin
        gm = gmode_e'({mode_comb_i, mode_ext_i});
        cfg_o.mute_fb = 1'b0;
        unique case (gm)
            GM_REG: begin
                cfg_o.pers = io_sel_i ? PERS_CIO : PERS_REG;
            end
            GM_COMPLEX: begin
                cfg_o.pers    = PERS_CIO;
                cfg_o.mute_fb = OUTER_CELL;
            end
            default: begin
                // simple, and the unused code taken as simple
                cfg_o.pers    = (io_sel_i && !CENTRE_CELL) ? PERS_IN : PERS_COUT;
                cfg_o.mute_fb = CENTRE_CELL;
            end
        endcase
    end
endmodule

// File: rtl/pmc_term_sum.sv
module pmc_term_sum
    import pmc_pkg::*;
#(
    parameter int NUM_PT  = 8,
    parameter int OE_TERM = 0
) (
    input  logic [NUM_PT-1:0] pterm_i,
    input  logic              pol_i,
    output logic              full_lvl_o,
    output logic              part_lvl_o,
    output logic              oe_term_o
);
    localparam logic [NUM_PT-1:0] PART_MASK = ~(NUM_PT'(1) << OE_TERM);

    always_comb begin
        full_lvl_o = apply_pol(|pterm_i, pol_i);
        part_lvl_o = apply_pol(|(pterm_i & PART_MASK), pol_i);
        oe_term_o  = pterm_i[OE_TERM];
    end
endmodule

// File: rtl/pmc_state_reg.sv
module pmc_state_reg (
    input  logic clk,
    input  logic rst,
    input  logic load_en_i,
    input  logic d_lvl_i,
    input  logic preload_i,
    input  logic preload_lvl_i,
    output logic lvl_o
);
    // Stored bit is the inverse of the pin level
    logic q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (preload_i) begin
            q <= ~preload_lvl_i;
        end else if (load_en_i) begin
            q <= ~d_lvl_i;
        end
    end

    assign lvl_o = ~q;
endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
    import pmc_pkg::*;
#(
    parameter int NUM_PT      = 8,
    parameter int OE_TERM     = 0,
    parameter bit OUTER_CELL  = 1'b0,
    parameter bit CENTRE_CELL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_comb_i,
    input  logic              mode_ext_i,
    input  logic [NUM_PT-1:0] pterm_i,
    input  logic              pol_i,
    input  logic              io_sel_i,
    input  logic              oe_n_i,
    input  logic              preload_i,
    input  logic              preload_lvl_i,
    input  logic              pad_in_i,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              fb_o
);
    cell_cfg_t cfg;
    logic      full_lvl, part_lvl, oe_term, reg_lvl;
    pad_t      drv;
    logic      pad_lvl, fb_raw;

    pmc_mode_decode #(
        .OUTER_CELL (OUTER_CELL),
        .CENTRE_CELL(CENTRE_CELL)
    ) u_dec (
        .mode_comb_i(mode_comb_i),
        .mode_ext_i (mode_ext_i),
        .io_sel_i   (io_sel_i),
        .cfg_o      (cfg)
    );

    pmc_term_sum #(
        .NUM_PT (NUM_PT),
        .OE_TERM(OE_TERM)
    ) u_sum (
        .pterm_i   (pterm_i),
        .pol_i     (pol_i),
        .full_lvl_o(full_lvl),
        .part_lvl_o(part_lvl),
        .oe_term_o (oe_term)
    );

    pmc_state_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .load_en_i    (cfg.pers == PERS_REG),
        .d_lvl_i      (full_lvl),
        .preload_i    (preload_i),
        .preload_lvl_i(preload_lvl_i),
        .lvl_o        (reg_lvl)
    );

    always_comb begin
        unique case (cfg.pers)
            PERS_REG:  drv = '{lvl: reg_lvl,  drive: ~oe_n_i};
            PERS_CIO:  drv = '{lvl: part_lvl, drive: oe_term};
            PERS_COUT: drv = '{lvl: full_lvl, drive: 1'b1};
            default:   drv = '{lvl: full_lvl, drive: 1'b0};
        endcase
        pad_lvl = drv.drive ? drv.lvl : pad_in_i;
        fb_raw  = (cfg.pers == PERS_REG) ? reg_lvl : pad_lvl;
    end

    assign pin_o    = drv.lvl;
    assign pin_oe_o = drv.drive;
    assign fb_o     = cfg.mute_fb ? 1'b0 : fb_raw;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NUM_PT      = 8,
    parameter bit OUTER_CELL  = 1'b0,
    parameter bit CENTRE_CELL = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_comb_i,
    input logic              mode_ext_i,
    input logic [NUM_PT-1:0] pterm_i,
    input logic              pol_i,
    input logic              io_sel_i,
    input logic              oe_n_i,
    input logic              preload_i,
    input logic              preload_lvl_i,
    input logic              pin_o,
    input logic              pin_oe_o,
    input logic              fb_o
);
    logic reg_mode;
    assign reg_mode = !mode_comb_i && mode_ext_i && !io_sel_i;

    // R3
    reg_next_state_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_mode) && reg_mode && !$past(rst) && !$past(preload_i))
        |-> (pin_o == ($past(pol_i) ? $past(|pterm_i) : !$past(|pterm_i))));

    // R3
    reg_feedback_chk: assert property (@(posedge clk) disable iff (rst)
        reg_mode |-> (fb_o == pin_o));

    // R4
    reg_enable_chk: assert property (@(posedge clk) disable iff (rst)
        reg_mode |-> (pin_oe_o == !oe_n_i));

    // R6
    outer_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (OUTER_CELL && mode_comb_i && mode_ext_i) |-> (fb_o == 1'b0));

    // R7
    simple_input_chk: assert property (@(posedge clk) disable iff (rst)
        (!CENTRE_CELL && mode_comb_i && !mode_ext_i && io_sel_i) |-> !pin_oe_o);

    // R8
    centre_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (CENTRE_CELL && mode_comb_i && !mode_ext_i) |-> (pin_oe_o && !fb_o));

    // R9
    reset_high_chk: assert property (@(posedge clk)
        ($past(rst) && reg_mode) |-> pin_o);

    // R10
    preload_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(preload_i) && !$past(rst) && reg_mode) |-> (pin_o == $past(preload_lvl_i)));
endmodule

bind pla_macrocell pmc_checker #(
    .NUM_PT     (NUM_PT),
    .OUTER_CELL (OUTER_CELL),
    .CENTRE_CELL(CENTRE_CELL)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_comb_i  (mode_comb_i),
    .mode_ext_i   (mode_ext_i),
    .pterm_i      (pterm_i),
    .pol_i        (pol_i),
    .io_sel_i     (io_sel_i),
    .oe_n_i       (oe_n_i),
    .preload_i    (preload_i),
    .preload_lvl_i(preload_lvl_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o),
    .fb_o         (fb_o)
);

// File: tb/pla_macrocell_bench.sv
module pla_macrocell_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_comb = 1'b0, mode_ext = 1'b1;
    logic [7:0] pterm = '0;
    logic       pol = 1'b0, io_sel = 1'b0, oe_n = 1'b0;
    logic       preload = 1'b0, preload_lvl = 1'b0, pad_in = 1'b0;
    logic       pin_a, oe_a, fb_a, pin_o, oe_o, fb_o, pin_c, oe_c, fb_c;
    int         checks = 0;
    int         fails  = 0;

    always #5 clk = ~clk;

    pla_macrocell u_pla_macrocell (
        .clk(clk), .rst(rst), .mode_comb_i(mode_comb), .mode_ext_i(mode_ext),
        .pterm_i(pterm), .pol_i(pol), .io_sel_i(io_sel), .oe_n_i(oe_n),
        .preload_i(preload), .preload_lvl_i(preload_lvl), .pad_in_i(pad_in),
        .pin_o(pin_a), .pin_oe_o(oe_a), .fb_o(fb_a));

    pla_macrocell #(.OUTER_CELL(1'b1)) u_pla_macrocell_outer (
        .clk(clk), .rst(rst), .mode_comb_i(mode_comb), .mode_ext_i(mode_ext),
        .pterm_i(pterm), .pol_i(pol), .io_sel_i(io_sel), .oe_n_i(oe_n),
        .preload_i(preload), .preload_lvl_i(preload_lvl), .pad_in_i(pad_in),
        .pin_o(pin_o), .pin_oe_o(oe_o), .fb_o(fb_o));

    pla_macrocell #(.CENTRE_CELL(1'b1)) u_pla_macrocell_centre (
        .clk(clk), .rst(rst), .mode_comb_i(mode_comb), .mode_ext_i(mode_ext),
        .pterm_i(pterm), .pol_i(pol), .io_sel_i(io_sel), .oe_n_i(oe_n),
        .preload_i(preload), .preload_lvl_i(preload_lvl), .pad_in_i(pad_in),
        .pin_o(pin_c), .pin_oe_o(oe_c), .fb_o(fb_c));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic c, input logic e, input logic io,
                           input logic p, input logic [7:0] t);
        mode_comb = c; mode_ext = e; io_sel = io; pol = p; pterm = t;
    endtask

    // registered step: drive at falling edge, check at the next falling edge
    task automatic reg_step(input logic p, input logic [7:0] t);
        @(negedge clk);
        pol = p; pterm = t;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
        rst = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 reset pin active-low", pin_a, 1'b1);
        pol = 1'b1; #1;
        chk("R9 reset pin active-high", pin_a, 1'b1);
        chk("R4 reset enable", oe_a, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_registered();
        reg_step(1'b1, 8'h80);
        chk("R3 term7 high", pin_a, 1'b1);
        chk("R3 feedback", fb_a, 1'b1);
        reg_step(1'b1, 8'h00);
        chk("R3 no term low", pin_a, 1'b0);
        chk("R3 feedback low", fb_a, 1'b0);
        reg_step(1'b0, 8'h01);
        chk("R2 active-low term0", pin_a, 1'b0);
        reg_step(1'b0, 8'h00);
        chk("R2 active-low none", pin_a, 1'b1);
        oe_n = 1'b1; #1;
        chk("R4 disabled", oe_a, 1'b0);
        chk("R3 feedback while disabled", fb_a, 1'b1);
        oe_n = 1'b0; #1;
        chk("R4 enabled", oe_a, 1'b1);
    endtask

    task automatic t_preload();
        @(negedge clk);
        pol = 1'b1; pterm = 8'hFF; preload = 1'b1; preload_lvl = 1'b0;
        @(negedge clk);
        chk("R10 preload low over terms", pin_a, 1'b0);
        pterm = 8'h00; preload_lvl = 1'b1;
        @(negedge clk);
        chk("R10 preload high", pin_a, 1'b1);
        preload = 1'b0;
        @(negedge clk);
        chk("R3 resume after preload", pin_a, 1'b0);
        preload = 1'b1; preload_lvl = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk("R10 reset beats preload", pin_a, 1'b1);
        preload = 1'b0; rst = 1'b0;
    endtask

    task automatic t_reg_io();
        @(negedge clk);
        pad_in = 1'b0;
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 8'h09); #1;
        chk("R5 enable from term0", oe_a, 1'b1);
        chk("R5 sum term3", pin_a, 1'b1);
        chk("R5 feedback pin", fb_a, 1'b1);
        pterm = 8'h01; #1;
        chk("R5 term0 excluded from sum", pin_a, 1'b0);
        pol = 1'b0; #1;
        chk("R2 combinatorial active-low", pin_a, 1'b1);
        pol = 1'b1; pterm = 8'h08; pad_in = 1'b1; #1;
        chk("R5 disabled", oe_a, 1'b0);
        chk("R5 feedback from pad high", fb_a, 1'b1);
        pad_in = 1'b0; #1;
        chk("R5 feedback from pad low", fb_a, 1'b0);
    endtask

    task automatic t_complex();
        @(negedge clk);
        pad_in = 1'b0;
        set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 8'h03); #1;
        chk("R6 io0 enable", oe_a, 1'b1);
        chk("R6 io0 pin", pin_a, 1'b1);
        chk("R6 inner feedback", fb_a, 1'b1);
        chk("R6 outer feedback muted", fb_o, 1'b0);
        io_sel = 1'b1; #1;
        chk("R6 io1 enable unchanged", oe_a, 1'b1);
        chk("R6 io1 pin unchanged", pin_a, 1'b1);
        pterm = 8'h02; pad_in = 1'b1; #1;
        chk("R6 disabled", oe_a, 1'b0);
        chk("R6 inner pad feedback", fb_a, 1'b1);
        chk("R6 outer pad feedback muted", fb_o, 1'b0);
        chk("R1 complex not registered", pin_a, 1'b1);
    endtask

    task automatic t_simple();
        @(negedge clk);
        pad_in = 1'b0;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'h00); #1;
        chk("R7 output pin", pin_a, 1'b1);
        chk("R7 always enabled", oe_a, 1'b1);
        chk("R7 feedback", fb_a, 1'b1);
        pol = 1'b1; pterm = 8'h01; #1;
        chk("R7 term0 counted", pin_a, 1'b1);
        oe_n = 1'b1; #1;
        chk("R7 shared enable ignored", oe_a, 1'b1);
        oe_n = 1'b0;
        io_sel = 1'b1; pad_in = 1'b1; #1;
        chk("R7 input disabled", oe_a, 1'b0);
        chk("R7 input feedback high", fb_a, 1'b1);
        pad_in = 1'b0; #1;
        chk("R7 input feedback low", fb_a, 1'b0);
        chk("R8 centre enabled", oe_c, 1'b1);
        chk("R8 centre pin", pin_c, 1'b1);
        chk("R8 centre feedback muted", fb_c, 1'b0);
    endtask

    task automatic t_reserved();
        @(negedge clk);
        pad_in = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 8'h00); #1;
        chk("R1 unused code input", oe_a, 1'b0);
        io_sel = 1'b0; #1;
        chk("R1 unused code output", oe_a, 1'b1);
        chk("R1 unused code pin", pin_a, 1'b0);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_registered();
        t_preload();
        t_reg_io();
        t_complex();
        t_simple();
        t_reserved();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule